// File: doc/BRIEF.md
# Variable Audio Delay Line Controller

This block delays a stream of audio samples by a programmable number of sample periods, using one synchronous single-port sample memory. Each sample period (nominally 44.1 kHz) a one-cycle tick brings in a new sample. The controller first reads the delayed sample out of memory and then, in the next clock cycle, writes the incoming sample into memory. The delayed sample goes to a registered output that holds its value until the next sample has been processed.

Two address counters produce the memory addresses. The write counter steps once per sample and wraps at the memory depth. The read counter trails it by the requested delay. Loading a new delay reloads the read counter with the write counter minus the delay, modulo the depth. A multiplexer selects which counter drives the memory address in each cycle. A delay of zero makes both counters equal, so the block reads a location and then writes the same location. This gives a fixed delay of one full memory depth, the same as a design with a single counter.

Top module: `audio_delay_line`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `memEn` is 0 and `sampleOut` is 0. Both counters reset to 0, so the delay after reset is 0.
- R2: A tick accepted by an idle controller produces exactly one read cycle (`memEn`=1, `memWe`=0) in the next clock cycle, then exactly one write cycle (`memEn`=1, `memWe`=1) in the cycle after that. `memEn` is 0 at all other times.
- R3: The write cycle for the k-th accepted tick since reset (k counted from 0) uses address k mod DEPTH. It writes the `sampleIn` value that was present with that tick.
- R4: The read cycle for tick k uses address (k − D) mod DEPTH, where D is the current delay setting after clamping.
- R5: For a delay D of 1 to DEPTH−1, the output produced for tick k is the sample from tick k−D. The memory starts out holding zero, so it is 0 when k < D.
- R6: A pulse on `delayLoad` while no memory cycle is in progress sets the delay to `delayValue`. A request larger than DEPTH−1 is clamped to DEPTH−1.
- R7: A delay setting of 0 reads and then writes the same address. The output for tick k is then the sample from tick k−DEPTH, or 0 while k < DEPTH.
- R8: `sampleOut` takes its new value on the clock edge that ends the write cycle and holds it at all other times.
- R9: A `sampleTick` that arrives while a read or write cycle is in progress is ignored: it causes no extra memory cycle and no output update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| sampleTick | input | 1 | One-cycle strobe marking a new sample period |
| sampleIn | input | DATA_W | Incoming audio sample, valid with `sampleTick` |
| delayLoad | input | 1 | Strobe that applies `delayValue` |
| delayValue | input | DLY_W | Requested delay in samples |
| sampleOut | output | DATA_W | Registered delayed sample |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable (1 = write, 0 = read) |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid one cycle after a read cycle |

## Verification
The assertions assume a synchronous memory that returns read data in the cycle after the read. They also assume that `delayLoad` is pulsed only while no memory cycle is in progress, because a load during a cycle is dropped without any sign at the ports. The stimulus leaves at least three idle cycles between ticks and after each load, so loads and ticks never overlap a memory cycle. The one exception is a deliberate tick held through a read cycle, which checks that a tick during a busy cycle is dropped. With these limits, the bench's own write counter and queue of expected samples track the design exactly, including the wrap of the addresses at the memory depth.

// File: rtl/adl_pkg.sv
package adl_pkg;

  // Strobes from the sequencer to the datapath, one set per clock cycle.
  typedef struct packed {
    logic latchIn;    // capture sampleIn (tick accepted)
    logic rdCycle;    // drive a read of the delayed sample
    logic wrCycle;    // drive the write of the captured sample, take read data
    logic loadDelay;  // reload read counter from write counter minus delay
  } adl_strobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_READ = 2'd1,
    SEQ_WRITE = 2'd2
  } adl_seq_t;

endpackage

// File: rtl/adl_control.sv
module adl_control
  import adl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleTick,
  input  logic         delayLoad,
  output adl_strobes_t strobes
);

  adl_seq_t seqState;
  adl_seq_t seqNext;

  always_comb begin
    seqNext = seqState;
    unique case (seqState)
      SEQ_IDLE:  if (sampleTick) seqNext = SEQ_READ;
      SEQ_READ:  seqNext = SEQ_WRITE;
      SEQ_WRITE: seqNext = SEQ_IDLE;
      default:   seqNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqState <= SEQ_IDLE;
    else       seqState <= seqNext;
  end

  always_comb begin
    strobes.latchIn   = (seqState == SEQ_IDLE) && sampleTick;
    strobes.loadDelay = (seqState == SEQ_IDLE) && delayLoad;
    strobes.rdCycle   = (seqState == SEQ_READ);
    strobes.wrCycle   = (seqState == SEQ_WRITE);
  end

endmodule

// File: rtl/adl_datapath.sv
module adl_datapath
  import adl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DLY_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  adl_strobes_t      strobes,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DLY_W-1:0]  delayValue,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] sampleOut,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] MAX_DLY = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic [ADDR_W-1:0] dlyClamped;
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;

  // Clamp only when the request field is wider than the address.
  generate
    if (DLY_W > ADDR_W) begin : g_clamp
      always_comb begin
        if (delayValue > DLY_W'(MAX_DLY)) dlyClamped = MAX_DLY;
        else                              dlyClamped = delayValue[ADDR_W-1:0];
      end
    end else begin : g_noclamp
      always_comb dlyClamped = ADDR_W'(delayValue);
    end
  endgenerate

  // Write counter: leads, steps once per processed sample.
  always_ff @(posedge clk) begin
    if (!rstN)                wrPtr <= '0;
    else if (strobes.wrCycle) wrPtr <= wrPtr + 1'b1;
  end

  // Read counter: loadable, trails the write counter by the delay.
  always_ff @(posedge clk) begin
    if (!rstN)                  rdPtr <= '0;
    else if (strobes.loadDelay) rdPtr <= wrPtr - dlyClamped;
    else if (strobes.wrCycle)   rdPtr <= rdPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                inReg <= '0;
    else if (strobes.latchIn) inReg <= sampleIn;
  end

  // Read data returns during the write cycle; keep it until the next one.
  always_ff @(posedge clk) begin
    if (!rstN)                outReg <= '0;
    else if (strobes.wrCycle) outReg <= memRdata;
  end

  always_comb begin
    memEn     = strobes.rdCycle | strobes.wrCycle;
    memWe     = strobes.wrCycle;
    memAddr   = strobes.wrCycle ? wrPtr : rdPtr;
    memWdata  = inReg;
    sampleOut = outReg;
  end

endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line
  import adl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DLY_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              delayLoad,
  input  logic [DLY_W-1:0]  delayValue,
  output logic [DATA_W-1:0] sampleOut,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  adl_strobes_t strobes;

  adl_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .delayLoad (delayLoad),
    .strobes   (strobes)
  );

  adl_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .DLY_W (DLY_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .delayValue(delayValue),
    .memRdata  (memRdata),
    .sampleOut (sampleOut),
    .memEn     (memEn),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

endmodule

// File: rtl/adl_delay_checker.sv
module adl_delay_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] sampleOut
);

  logic [ADDR_W-1:0] wrCount;

  always_ff @(posedge clk) begin
    if (!rstN)              wrCount <= '0;
    else if (memEn && memWe) wrCount <= wrCount + 1'b1;
  end

  // R1: quiet memory port and zero output right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!memEn && sampleOut == '0));

  // R2: every read is followed by a write in the next cycle
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (memEn && memWe));

  // R2: every write was preceded by a read
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> $past(memEn && !memWe));

  // R3: write addresses step through the memory in order and wrap
  a_r3_write_sequence: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (memAddr == wrCount));

  // R8: output changes only on the edge that ends a write cycle
  a_r8_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(memEn && memWe) |-> $stable(sampleOut));

endmodule

bind audio_delay_line adl_delay_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_delay_checker (
  .clk      (clk),
  .rstN     (rstN),
  .memEn    (memEn),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .sampleOut(sampleOut)
);

// File: tb/audio_delay_line_bench.sv
module audio_delay_line_bench;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int DLY_W  = 12;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleTick = 1'b0;
  logic [DATA_W-1:0] sampleIn = '0;
  logic              delayLoad = 1'b0;
  logic [DLY_W-1:0]  delayValue = '0;
  logic [DATA_W-1:0] sampleOut;
  logic              memEn;
  logic              memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = '0;

  always #2.5 clk = ~clk;

  audio_delay_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_audio_delay_line (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .sampleIn(sampleIn),
    .delayLoad(delayLoad), .delayValue(delayValue), .sampleOut(sampleOut),
    .memEn(memEn), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata)
  );

  // Synchronous single-port memory model, cleared to zero.
  logic [DATA_W-1:0] ram [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) ram[memAddr] <= memWdata;
      else       memRdata <= ram[memAddr];
    end
  end

  int vectors = 0;
  int miscompares = 0;
  int tickNum = 0;
  int delayEff = DEPTH;
  string phaseTag = "R7";
  logic [DATA_W-1:0] hist [4096];

  int    rdQ[$];
  int    wrAddrQ[$];
  int    wrDataQ[$];
  int    outQ[$];
  string tagQ[$];

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: one tick, expectations pushed to the scoreboard.
  task automatic doTick(input logic [DATA_W-1:0] data, input int holdCycles);
    int src;
    @(negedge clk);
    sampleTick = 1'b1;
    sampleIn = data;
    hist[tickNum] = data;
    src = tickNum - delayEff;
    rdQ.push_back((tickNum + DEPTH - delayEff) % DEPTH);
    wrAddrQ.push_back(tickNum % DEPTH);
    wrDataQ.push_back(int'(data));
    outQ.push_back(src >= 0 ? int'(hist[src]) : 0);
    tagQ.push_back(phaseTag);
    tickNum++;
    repeat (holdCycles) @(negedge clk);
    sampleTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic setDelay(input int value, input string tag);
    int c;
    @(negedge clk);
    delayLoad = 1'b1;
    delayValue = DLY_W'(value);
    c = (value > DEPTH - 1) ? DEPTH - 1 : value;
    delayEff = (c == 0) ? DEPTH : c;
    phaseTag = tag;
    @(negedge clk);
    delayLoad = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: compares memory cycles and outputs against the queues.
  logic pendOut = 1'b0;
  logic prevRead = 1'b0;
  int lastOut = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pendOut) begin
        if (outQ.size() == 0) check("R8", sampleOut, lastOut);
        else begin
          lastOut = outQ.pop_front();
          check(tagQ.pop_front(), sampleOut, lastOut);
        end
      end else begin
        check("R8", sampleOut, lastOut);
      end
      pendOut = 1'b0;
      if (memEn && !memWe) begin
        if (rdQ.size() == 0) check("R9 unexpected read", 1, 0);
        else check("R4", memAddr, rdQ.pop_front());
      end else if (memEn && memWe) begin
        check("R2", prevRead, 1);
        if (wrAddrQ.size() == 0) check("R9 unexpected write", 1, 0);
        else begin
          check("R3 addr", memAddr, wrAddrQ.pop_front());
          check("R3 data", memWdata, wrDataQ.pop_front());
        end
        pendOut = 1'b1;
      end
      prevRead = memEn && !memWe;
    end
  end

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 memEn", memEn, 0);
    check("R1 out", sampleOut, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 memEn", memEn, 0);
    check("R1 out", sampleOut, 0);

    // Delay 0 after reset: full-depth delay through the wrap.
    for (int i = 0; i < DEPTH + 20; i++) doTick(DATA_W'(i * 37 + 11), 1);

    setDelay(5, "R5");
    for (int i = 0; i < 20; i++) doTick(DATA_W'(16'hA000 ^ (i * 91)), 1);
    setDelay(1, "R5");
    for (int i = 0; i < 10; i++) doTick(DATA_W'(16'h5A5A + i * 3), 1);

    // Tick held into the read cycle: second cycle must be dropped.
    doTick(16'hBEEF, 2);
    doTick(16'h1234, 2);

    setDelay(3000, "R6");
    for (int i = 0; i < 20; i++) doTick(DATA_W'(i * 1237), 1);
    setDelay(DEPTH - 1, "R6");
    for (int i = 0; i < 10; i++) doTick(DATA_W'(16'hC0DE - i), 1);
    setDelay(DEPTH, "R6");
    for (int i = 0; i < 10; i++) doTick(DATA_W'(16'h0F0F + i * 7), 1);
    setDelay(0, "R7");
    for (int i = 0; i < 10; i++) doTick(DATA_W'(i * 5 + 1), 1);

    repeat (6) @(negedge clk);
    check("R2 queue drained", rdQ.size() + wrAddrQ.size() + outQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule